// File: doc/BRIEF.md
# Half-Bridge Gate Guard and Fault Status

This block sits between the serial control register of a triple half-bridge driver and its gate drivers. When a new control word is committed it captures six switch requests (low-side and high-side for each of three bridges) and an overcurrent-shutdown enable. It then produces six gate enables. No bridge ever has both of its switches on at once. All gates are dropped during standby or supply undervoltage. A switch that sees a short circuit while shutdown is enabled is latched off.

The block also builds the 16-bit status word that the serial link shifts out. The word carries the live thermal prewarning, the live on/off state of every switch, and three sticky fault summaries: short-circuit shutdown, open load and supply fail. A committed word with its status-clear bit set resets the sticky summaries. The live switch bits are left alone. Analog comparators, thresholds and the charge pump are outside the block; it consumes only their digital flags.

Top module: `hbridge_guard`

## Requirements
- R1: Switch index i maps to LS1, HS1, LS2, HS2, LS3, HS3 for i = 0..5, so bridge k owns low side 2k and high side 2k+1. A commit (`wordValid` high at a rising edge) loads `swReq`, and from that edge `gateEn[i]` follows `swReq[i]`.
- R2: If both switches of one bridge are requested, both gate enables of that bridge are low. The other bridges are unaffected.
- R3: While `inhibit` is low or `underVolt` is high, all gate enables are low, with no clock delay. The captured requests are kept, and the gates return once both conditions clear, without a new commit.
- R4: With overcurrent shutdown enabled, a switch whose gate is on and whose `shortFlag` bit is high at a rising edge without a commit is off from that edge on, until the next commit. With shutdown disabled, `shortFlag` has no effect on the gates.
- R5: Status bit 0 equals `thermWarn` combinationally. Bits 1..6 equal `gateEn[0..5]`. Bits 7..12 read zero.
- R6: Status bit 13 is set at any edge where a switch is tripped off by R4, and stays set until cleared.
- R7: Status bit 14 is set at any edge where some switch has its gate on and its `openFlag` bit high, and stays set until cleared. An open flag on a switch that is off has no effect.
- R8: Status bit 15 is set at any edge where `underVolt` is high, and stays set until cleared.
- R9: A commit with `statusClr` high clears bits 13..15 at that edge, unless a set condition holds at the same edge, in which case the set wins. Recommitting the same switch pattern with the clear leaves bits 1..6 unchanged, apart from re-enabling switches that R4 tripped.
- R10: While `rstN` is low, the requests, trips and sticky bits are zero, so `gateEn` is zero and the status word is zero apart from bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wordValid | input | 1 | Commit strobe for a new control word |
| swReq | input | 6 | Requested switch states, index order per R1 |
| ocEnable | input | 1 | Overcurrent shutdown enable in the committed word |
| statusClr | input | 1 | Status-clear request in the committed word |
| inhibit | input | 1 | Low selects standby, high selects normal operation |
| shortFlag | input | 6 | Per-switch short-circuit comparator flags |
| openFlag | input | 6 | Per-switch open-load comparator flags |
| underVolt | input | 1 | Supply undervoltage flag |
| thermWarn | input | 1 | Thermal prewarning flag |
| gateEn | output | 6 | Gate enables, index order per R1 |
| statusWord | output | 16 | Status word for the serial link |

## Verification
The assertions take the comparator flags and the commit strobe to be synchronous to `clk` and held at zero while reset is active. The sticky-bit properties compare flag values at one edge with the status word after it, so they depend on that assumption. The stimulus changes every input only on the falling clock edge and keeps every flag low through reset, including the mid-run reset. The sweep walks all 64 request patterns under each combination of standby and undervoltage.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  localparam int STATUS_W   = 16;
  localparam int TEMP_BIT   = 0;
  localparam int SW_BASE    = 1;
  localparam int SHORT_BIT  = 13;
  localparam int OPEN_BIT   = 14;
  localparam int SUPPLY_BIT = 15;

  typedef struct packed {
    logic loadWord;
    logic clearStatus;
    logic forceOff;
  } ctrlStrobes_t;
endpackage

// File: rtl/hbg_ctrl.sv
module hbg_ctrl
  import hbg_pkg::*;
(
  input  logic         wordValid,
  input  logic         statusClr,
  input  logic         inhibit,
  input  logic         underVolt,
  output ctrlStrobes_t strobes
);
  always_comb begin
    strobes.loadWord    = wordValid;
    strobes.clearStatus = wordValid & statusClr;
    strobes.forceOff    = ~inhibit | underVolt;
  end
endmodule

// File: rtl/hbg_datapath.sv
module hbg_datapath
  import hbg_pkg::*;
#(
  parameter int NUM_BRIDGES = 3,
  localparam int SW_W = 2 * NUM_BRIDGES
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [SW_W-1:0]     swReq,
  input  logic                ocEnable,
  input  logic [SW_W-1:0]     shortFlag,
  input  logic [SW_W-1:0]     openFlag,
  input  logic                underVolt,
  input  logic                thermWarn,
  output logic [SW_W-1:0]     gateEn,
  output logic [STATUS_W-1:0] statusWord
);
  logic [SW_W-1:0] reqReg;
  logic [SW_W-1:0] tripReg;
  logic [SW_W-1:0] tripSet;
  logic            ocEnReg;
  logic            shortSticky;
  logic            openSticky;
  logic            supplySticky;
  logic            shortEvent;
  logic            openEvent;

  for (genvar k = 0; k < NUM_BRIDGES; k++) begin : g_bridge
    logic conflict;
    assign conflict = reqReg[2*k] & reqReg[2*k+1];
    assign gateEn[2*k]   = reqReg[2*k]   & ~tripReg[2*k]   & ~conflict & ~strobes.forceOff;
    assign gateEn[2*k+1] = reqReg[2*k+1] & ~tripReg[2*k+1] & ~conflict & ~strobes.forceOff;
  end

  assign tripSet    = ocEnReg ? (gateEn & shortFlag) : '0;
  assign shortEvent = (|tripSet) & ~strobes.loadWord;
  assign openEvent  = |(gateEn & openFlag);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqReg  <= '0;
      ocEnReg <= 1'b1;
      tripReg <= '0;
    end else if (strobes.loadWord) begin
      reqReg  <= swReq;
      ocEnReg <= ocEnable;
      tripReg <= '0;
    end else begin
      tripReg <= tripReg | tripSet;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shortSticky  <= 1'b0;
      openSticky   <= 1'b0;
      supplySticky <= 1'b0;
    end else begin
      shortSticky  <= (shortSticky  & ~strobes.clearStatus) | shortEvent;
      openSticky   <= (openSticky   & ~strobes.clearStatus) | openEvent;
      supplySticky <= (supplySticky & ~strobes.clearStatus) | underVolt;
    end
  end

  always_comb begin
    statusWord                   = '0;
    statusWord[TEMP_BIT]         = thermWarn;
    statusWord[SW_BASE +: SW_W]  = gateEn;
    statusWord[SHORT_BIT]        = shortSticky;
    statusWord[OPEN_BIT]         = openSticky;
    statusWord[SUPPLY_BIT]       = supplySticky;
  end
endmodule

// File: rtl/hbridge_guard.sv
module hbridge_guard
  import hbg_pkg::*;
#(
  parameter int NUM_BRIDGES = 3,
  localparam int SW_W = 2 * NUM_BRIDGES
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wordValid,
  input  logic [SW_W-1:0]     swReq,
  input  logic                ocEnable,
  input  logic                statusClr,
  input  logic                inhibit,
  input  logic [SW_W-1:0]     shortFlag,
  input  logic [SW_W-1:0]     openFlag,
  input  logic                underVolt,
  input  logic                thermWarn,
  output logic [SW_W-1:0]     gateEn,
  output logic [STATUS_W-1:0] statusWord
);
  ctrlStrobes_t strobes;

  hbg_ctrl u_ctrl (
    .wordValid (wordValid),
    .statusClr (statusClr),
    .inhibit   (inhibit),
    .underVolt (underVolt),
    .strobes   (strobes)
  );

  hbg_datapath #(.NUM_BRIDGES(NUM_BRIDGES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .swReq      (swReq),
    .ocEnable   (ocEnable),
    .shortFlag  (shortFlag),
    .openFlag   (openFlag),
    .underVolt  (underVolt),
    .thermWarn  (thermWarn),
    .gateEn     (gateEn),
    .statusWord (statusWord)
  );
endmodule

// File: rtl/hbg_checker.sv
module hbg_checker
  import hbg_pkg::*;
#(
  parameter int NUM_BRIDGES = 3,
  localparam int SW_W = 2 * NUM_BRIDGES
) (
  input logic                clk,
  input logic                rstN,
  input logic                wordValid,
  input logic                statusClr,
  input logic                inhibit,
  input logic                underVolt,
  input logic [SW_W-1:0]     openFlag,
  input logic [SW_W-1:0]     gateEn,
  input logic [STATUS_W-1:0] statusWord
);
  for (genvar k = 0; k < NUM_BRIDGES; k++) begin : g_chk
    assert_no_shoot_through_R2: assert property (@(posedge clk) disable iff (!rstN)
      !(gateEn[2*k] && gateEn[2*k+1]));
  end

  assert_forced_off_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!inhibit || underVolt) |-> (gateEn == '0));

  assert_open_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(|(gateEn & openFlag))) |-> statusWord[OPEN_BIT]);

  assert_supply_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(underVolt)) |-> statusWord[SUPPLY_BIT]);

  assert_supply_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wordValid && statusClr && !underVolt)) |-> !statusWord[SUPPLY_BIT]);
endmodule

bind hbridge_guard hbg_checker #(.NUM_BRIDGES(NUM_BRIDGES)) u_hbg_checker (.*);

// File: tb/test_hbridge_guard.sv
module test_hbridge_guard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wordValid = 1'b0;
  logic [5:0]  swReq = '0;
  logic        ocEnable = 1'b1;
  logic        statusClr = 1'b0;
  logic        inhibit = 1'b1;
  logic [5:0]  shortFlag = '0;
  logic [5:0]  openFlag = '0;
  logic        underVolt = 1'b0;
  logic        thermWarn = 1'b0;
  logic [5:0]  gateEn;
  logic [15:0] statusWord;

  int  nChecks = 0;
  int  nFails = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;

  hbridge_guard i_hbridge_guard (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .swReq(swReq),
    .ocEnable(ocEnable), .statusClr(statusClr), .inhibit(inhibit),
    .shortFlag(shortFlag), .openFlag(openFlag), .underVolt(underVolt),
    .thermWarn(thermWarn), .gateEn(gateEn), .statusWord(statusWord)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] expGate(input logic [5:0] req, input logic inh, input logic uv);
    logic [5:0] g;
    for (int k = 0; k < 3; k++) begin
      logic both;
      both = req[2*k] & req[2*k+1];
      g[2*k]   = req[2*k]   & ~both;
      g[2*k+1] = req[2*k+1] & ~both;
    end
    return (inh && !uv) ? g : 6'b0;
  endfunction

  task automatic commit(input logic [5:0] req, input logic oc, input logic clr);
    @(negedge clk);
    swReq = req; ocEnable = oc; statusClr = clr; wordValid = 1'b1;
    @(negedge clk);
    wordValid = 1'b0; statusClr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset gates", {10'b0, gateEn}, 16'h0);
    check("R10 reset status", statusWord, 16'h0);
    rstN = 1'b1;

    for (int m = 0; m < 4; m++) begin
      for (int r = 0; r < 64; r++) begin
        logic [5:0] eg;
        inhibit   = m[0] ? 1'b0 : 1'b1;
        underVolt = m[1];
        commit(r[5:0], 1'b1, 1'b1);
        eg = expGate(r[5:0], inhibit, underVolt);
        if (!inhibit || underVolt)
          check("R3 forced off", {10'b0, gateEn}, {10'b0, eg});
        else if (eg != r[5:0])
          check("R2 bridge conflict", {10'b0, gateEn}, {10'b0, eg});
        else
          check("R1 gate follows request", {10'b0, gateEn}, {10'b0, eg});
        check("R5 R8 R9 status word", statusWord, {underVolt, 2'b00, 6'b0, eg, 1'b0});
      end
    end

    underVolt = 1'b0; inhibit = 1'b1;
    commit(6'b010110, 1'b1, 1'b1);
    @(negedge clk); inhibit = 1'b0;
    #1 check("R3 standby drops gates", {10'b0, gateEn}, 16'h0);
    @(negedge clk); inhibit = 1'b1;
    #1 check("R3 gates restored without commit", {10'b0, gateEn}, 16'h0016);

    thermWarn = 1'b1;
    #1 check("R5 thermal bit", {15'b0, statusWord[0]}, 16'h1);
    thermWarn = 1'b0;
    #1 check("R5 thermal bit low", {15'b0, statusWord[0]}, 16'h0);

    commit(6'b000001, 1'b1, 1'b1);
    shortFlag = 6'b000001;
    @(negedge clk); shortFlag = '0;
    check("R4 trip drops LS1", {10'b0, gateEn}, 16'h0);
    check("R6 short sticky", {15'b0, statusWord[13]}, 16'h1);
    repeat (3) @(negedge clk);
    check("R4 trip held", {10'b0, gateEn}, 16'h0);
    check("R6 short still set", {15'b0, statusWord[13]}, 16'h1);
    commit(6'b000001, 1'b1, 1'b1);
    check("R9 recommit reenables", {10'b0, gateEn}, 16'h0001);
    check("R9 short cleared", {15'b0, statusWord[13]}, 16'h0);

    commit(6'b000110, 1'b1, 1'b0);
    shortFlag = 6'b000100;
    @(negedge clk); shortFlag = '0;
    check("R4 only shorted switch tripped", {10'b0, gateEn}, 16'h0002);

    commit(6'b000001, 1'b0, 1'b1);
    shortFlag = 6'b000001;
    @(negedge clk); @(negedge clk); shortFlag = '0;
    check("R4 shutdown disabled keeps gate", {10'b0, gateEn}, 16'h0001);
    check("R6 no short when disabled", {15'b0, statusWord[13]}, 16'h0);

    commit(6'b010000, 1'b1, 1'b1);
    openFlag = 6'b000001;
    @(negedge clk); openFlag = '0;
    check("R7 open on off switch ignored", {15'b0, statusWord[14]}, 16'h0);
    openFlag = 6'b010000;
    @(negedge clk); openFlag = '0;
    @(negedge clk);
    check("R7 open sticky", {15'b0, statusWord[14]}, 16'h1);
    commit(6'b010000, 1'b1, 1'b1);
    check("R9 clear keeps switch bits", statusWord, 16'h0020);

    underVolt = 1'b1;
    @(negedge clk); underVolt = 1'b0;
    @(negedge clk);
    check("R8 supply sticky", statusWord, 16'h8020);
    check("R3 gates back after undervoltage", {10'b0, gateEn}, 16'h0010);

    rstN = 1'b0;
    #1 check("R10 mid-run reset", {gateEn, statusWord[15:6]}, 16'h0);
    @(negedge clk); rstN = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule